// File: doc/BRIEF.md
# Stream Channel Gate with Hardware Drain

This block provides per-channel control and status for a set of host streaming channels. Each channel has one valid/ready input stream and one output stream, with a small word buffer between them. A register port lets the host open and close each channel, set a frame length and choose how bytes are reordered inside each data word. The first group of channels is the transmit side. The rest is the receive side. A global status word shows which channels are still live.

Closing a channel does not throw away its buffer all at once. The channel drains itself one word per cycle and keeps its busy flag raised until the buffer is empty. A host that must recover from an unclean shutdown closes every channel, polls busy until it falls, and then reopens. If the host asks to open a channel while it is still draining, the open is deferred until the buffer is empty, so old words never reach the new stream. That request also latches an error flag.

Back-pressure rules:
- While a channel is open, a word is accepted on a cycle where `s_valid` and `s_ready` are both high. A word leaves on a cycle where `m_valid` and `m_ready` are both high.
- While open, `m_valid` never drops, and `m_data` never changes, until the word is taken or the host writes the control register.
- While closed, `s_ready` is held high and every offered word is dropped.

Top module: `dma_flush_ctrl`

## Requirements
- R1: After reset, every channel is closed and has an empty buffer. `s_ready` is high, `m_valid` is low, and every register reads 0.
- R2: Transmit channel c uses addresses 0x200+0x10*c and receive channel c uses 0x400+0x10*c. Within a group, offset 0x0 is control/status and offset 0x4 is frame length. The global status word is at 0x020. Every other address reads 0. Control readback bit layout: bit 0 error, bit 1 busy, bit 2 stored open request, bits 5:4 stored reorder code, bit 8 running. All other readback bits are 0.
- R3: A running channel passes words in the order they were accepted, and back-pressure applies from the output side only. `s_ready` is low only when the buffer holds 8 words. `m_valid` is high whenever the buffer is not empty.
- R4: A channel that is not running keeps `s_ready` high and `m_valid` low, and none of the words it accepts reach the output.
- R5: Control bit 1 is the open request. Writing 0 closes the channel. Busy (readback bit 1) is high exactly while the buffer is not empty. After a close, the channel drops one buffered word per cycle, so busy falls within 8 cycles.
- R6: An open request takes effect in the same cycle only if the buffer is empty or the channel is already running. Otherwise the channel stays stopped and starts running on the first clock edge after the buffer has become empty.
- R7: The error flag (readback bit 0) is set by an open request written while the channel is stopped with a non-empty buffer. It then stays set until a control write with bit 0 high clears it. Clearing wins over setting in the same write.
- R8: Control bit 0 is a one-shot clear and is not stored. A write with bit 0 high leaves readback bit 0 at 0 on the following cycles.
- R9: Control bits 5:4 set the unit size for reordering accepted words: 0 selects bytes, 1 selects 16-bit units, 2 selects 32-bit units, 3 selects 64-bit units. The order of the units inside the word is reversed. For example, 0x0011223344556677 becomes 0x7766554433221100, 0x6677445522330011, 0x4455667700112233, or stays unchanged.
- R10: The frame-length register counts data words. `m_last` is high on every N-th word leaving an open channel, where N is the register value and 0 counts as 1. The count restarts whenever the channel stops running.
- R11: In the global status word, bit 16+c shows transmit channel c and bit 24+c shows receive channel c. A bit is high while that channel is running or its buffer is not empty. Each side supports at most six channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address (byte offset) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 32 | Read data, combinational on reg_raddr |
| s_valid | input | NCH | Per-channel input word valid |
| s_ready | output | NCH | Per-channel input word accepted |
| s_data | input | NCH*DATA_W | Input words, channel c at slice c |
| m_valid | output | NCH | Per-channel output word valid |
| m_ready | input | NCH | Per-channel output word taken |
| m_data | output | NCH*DATA_W | Output words, channel c at slice c |
| m_last | output | NCH | Last word of a frame |

## Verification
If a channel's run state is wrong, the output side shows it in the very next cycle: `m_valid` rises from a channel the host has closed, or `s_ready` falls on a closed channel. A drain that fails to advance shows as busy staying high in the status readback for more than eight cycles. A buffer pointer that is off leaves out-of-order or repeated words at the head, and the reference model's data comparison catches them at the first handshake. A wrong frame counter puts `m_last` on the wrong word within one frame, and a wrong reorder unit corrupts the first word after it is selected.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  localparam int TX_BASE     = 'h200;
  localparam int RX_BASE     = 'h400;
  localparam int CH_STRIDE   = 'h10;
  localparam int OFS_CTRL    = 'h0;
  localparam int OFS_FRAME   = 'h4;
  localparam int GSTAT_ADDR  = 'h020;
  localparam int GSTAT_TX_LO = 16;
  localparam int GSTAT_RX_LO = 24;
  localparam int MAX_PER_DIR = 6;

  typedef struct packed {
    logic [1:0] gran;
    logic       open_req;
    logic       clr;
  } ctrl_word_t;

  function automatic ctrl_word_t unpack_ctrl(input logic [31:0] w);
    ctrl_word_t c;
    c.gran     = w[5:4];
    c.open_req = w[1];
    c.clr      = w[0];
    return c;
  endfunction

  function automatic int chan_base(input int ch, input int num_tx);
    if (ch < num_tx) return TX_BASE + ch * CH_STRIDE;
    return RX_BASE + (ch - num_tx) * CH_STRIDE;
  endfunction

endpackage

// File: rtl/dsc_swap.sv
module dsc_swap #(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        gran,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [3:0][DATA_W-1:0] variant;

  for (genvar g = 0; g < 4; g++) begin : g_gran
    localparam int UNIT = 8 << g;
    if (DATA_W % UNIT == 0) begin : g_rev
      localparam int NUNITS = DATA_W / UNIT;
      for (genvar k = 0; k < NUNITS; k++) begin : g_unit
        assign variant[g][k*UNIT +: UNIT] = din[(NUNITS-1-k)*UNIT +: UNIT];
      end
    end else begin : g_pass
      assign variant[g] = din;
    end
  end

  assign dout = variant[gran];
endmodule

// File: rtl/dsc_fifo.sv
module dsc_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;

  assign empty = (fill == '0);
  assign full  = (fill == (AW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/dsc_channel.sv
module dsc_channel #(
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 8,
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  dsc_pkg::ctrl_word_t ctrl,
  input  logic               frame_we,
  input  logic [FRAME_W-1:0] frame_val,
  output logic [31:0]        ctrl_rd,
  output logic [FRAME_W-1:0] frame_rd,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [DATA_W-1:0]  m_data,
  output logic               m_last,
  output logic               run_o,
  output logic               busy_o,
  output logic               err_o,
  output logic               active_o
);
  logic               open_req, running, err;
  logic [1:0]         gran;
  logic [FRAME_W-1:0] fsize, fpos, last_pos;
  logic               open_nxt, push, pop, empty, full, hs_out;
  logic [DATA_W-1:0]  swapped;

  dsc_swap #(.DATA_W(DATA_W)) u_swap (
    .gran (gran),
    .din  (s_data),
    .dout (swapped)
  );

  dsc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (swapped),
    .pop   (pop),
    .dout  (m_data),
    .empty (empty),
    .full  (full)
  );

  assign open_nxt = ctrl_we ? ctrl.open_req : open_req;
  assign s_ready  = running ? !full : 1'b1;
  assign push     = running && s_valid && !full;
  assign m_valid  = running && !empty;
  assign hs_out   = m_valid && m_ready;
  assign pop      = running ? hs_out : !empty;
  assign last_pos = (fsize == '0) ? '0 : fsize - 1'b1;
  assign m_last   = (fpos >= last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_req <= 1'b0;
      running  <= 1'b0;
      err      <= 1'b0;
      gran     <= 2'd0;
      fsize    <= '0;
      fpos     <= '0;
    end else begin
      open_req <= open_nxt;
      running  <= open_nxt && (running || empty);
      if (ctrl_we) gran <= ctrl.gran;
      if (frame_we) fsize <= frame_val;
      if (ctrl_we && ctrl.clr)
        err <= 1'b0;
      else if (ctrl_we && ctrl.open_req && !running && !empty)
        err <= 1'b1;
      if (!running)   fpos <= '0;
      else if (hs_out) fpos <= m_last ? '0 : fpos + 1'b1;
    end
  end

  assign busy_o   = !empty;
  assign run_o    = running;
  assign err_o    = err;
  assign active_o = running || !empty;
  assign frame_rd = fsize;
  assign ctrl_rd  = {23'd0, running, 2'd0, gran, 1'b0, open_req, !empty, err};
endmodule

// File: rtl/dma_flush_ctrl.sv
module dma_flush_ctrl #(
  parameter int NUM_TX  = 2,
  parameter int NUM_RX  = 2,
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 8,
  parameter int FRAME_W = 32,
  parameter int ADDR_W  = 12,
  localparam int NCH    = NUM_TX + NUM_RX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  input  logic [ADDR_W-1:0]     reg_raddr,
  output logic [31:0]           reg_rdata,
  input  logic [NCH-1:0]        s_valid,
  output logic [NCH-1:0]        s_ready,
  input  logic [NCH*DATA_W-1:0] s_data,
  output logic [NCH-1:0]        m_valid,
  input  logic [NCH-1:0]        m_ready,
  output logic [NCH*DATA_W-1:0] m_data,
  output logic [NCH-1:0]        m_last
);
  import dsc_pkg::*;

  logic [NCH-1:0]              ch_ctrl_we, ch_frame_we;
  logic [NCH-1:0]              ch_run, ch_busy, ch_err, ch_active;
  logic [NCH-1:0][31:0]        ch_ctrl_rd;
  logic [NCH-1:0][FRAME_W-1:0] ch_frame_rd;
  logic [31:0]                 gstat;
  ctrl_word_t                  ctrl_dec;

  assign ctrl_dec = unpack_ctrl(reg_wdata);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(chan_base(c, NUM_TX));
    assign ch_ctrl_we[c]  = reg_wr && (reg_addr == BASE + ADDR_W'(OFS_CTRL));
    assign ch_frame_we[c] = reg_wr && (reg_addr == BASE + ADDR_W'(OFS_FRAME));

    dsc_channel #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ch_ctrl_we[c]),
      .ctrl      (ctrl_dec),
      .frame_we  (ch_frame_we[c]),
      .frame_val (reg_wdata[FRAME_W-1:0]),
      .ctrl_rd   (ch_ctrl_rd[c]),
      .frame_rd  (ch_frame_rd[c]),
      .s_valid   (s_valid[c]),
      .s_ready   (s_ready[c]),
      .s_data    (s_data[c*DATA_W +: DATA_W]),
      .m_valid   (m_valid[c]),
      .m_ready   (m_ready[c]),
      .m_data    (m_data[c*DATA_W +: DATA_W]),
      .m_last    (m_last[c]),
      .run_o     (ch_run[c]),
      .busy_o    (ch_busy[c]),
      .err_o     (ch_err[c]),
      .active_o  (ch_active[c])
    );
  end

  always_comb begin
    gstat = '0;
    for (int i = 0; i < NUM_TX && i < MAX_PER_DIR; i++) gstat[GSTAT_TX_LO+i] = ch_active[i];
    for (int i = 0; i < NUM_RX && i < MAX_PER_DIR; i++) gstat[GSTAT_RX_LO+i] = ch_active[NUM_TX+i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == ADDR_W'(GSTAT_ADDR)) reg_rdata = gstat;
    for (int c = 0; c < NCH; c++) begin
      if (reg_raddr == ADDR_W'(chan_base(c, NUM_TX) + OFS_CTRL))  reg_rdata = ch_ctrl_rd[c];
      if (reg_raddr == ADDR_W'(chan_base(c, NUM_TX) + OFS_FRAME)) reg_rdata = 32'(ch_frame_rd[c]);
    end
  end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int NCH    = 4,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        run,
  input logic [NCH-1:0]        busy,
  input logic [NCH-1:0]        err,
  input logic [NCH-1:0]        ctrl_we,
  input logic                  clr_bit,
  input logic [NCH-1:0]        s_ready,
  input logic [NCH-1:0]        m_valid,
  input logic [NCH-1:0]        m_ready,
  input logic [NCH*DATA_W-1:0] m_data
);
  localparam int CW = $clog2(DEPTH + 2) + 1;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [CW-1:0] drain_cnt;

    always_ff @(posedge clk) begin
      if (!rst_n)                 drain_cnt <= '0;
      else if (busy[c] && !run[c]) drain_cnt <= drain_cnt + 1'b1;
      else                        drain_cnt <= '0;
    end

    AST_FLUSH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      drain_cnt <= CW'(DEPTH)); // R5

    AST_OFF_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |-> (s_ready[c] && !m_valid[c])); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[c] && !m_ready[c] && !ctrl_we[c]) |=>
        (m_valid[c] && $stable(m_data[c*DATA_W +: DATA_W]))); // R3

    AST_RUN_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[c]) |-> $past(!busy[c])); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err[c] && !(ctrl_we[c] && clr_bit)) |=> err[c]); // R7
  end
endmodule

bind dma_flush_ctrl dsc_checker #(
  .NCH    (NUM_TX + NUM_RX),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (ch_run),
  .busy    (ch_busy),
  .err     (ch_err),
  .ctrl_we (ch_ctrl_we),
  .clr_bit (reg_wdata[0]),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data)
);

// File: tb/tb_dma_flush_ctrl.sv
`timescale 1ns/1ps
module tb_dma_flush_ctrl;
  localparam int NTX = 2, NRX = 2, NC = NTX + NRX, DW = 64, DEP = 8, FW = 32, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NC-1:0] s_valid = '0, s_ready, m_valid, m_ready = '0, m_last;
  logic [NC*DW-1:0] s_data = '0, m_data;

  always #2.5 clk = ~clk;

  dma_flush_ctrl #(.NUM_TX(NTX), .NUM_RX(NRX), .DATA_W(DW), .DEPTH(DEP),
                   .FRAME_W(FW), .ADDR_W(AW)) dut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // reference model state
  logic [DW-1:0] mq [NC][$];
  bit mrun [NC], men [NC], merr [NC];
  int mgran [NC], mfs [NC], mpos [NC];

  // stimulus knobs and captured outputs
  int vp = 0, rp = 0;
  bit fixed_en = 0, rnd_rd = 0;
  logic [DW-1:0] fixed_word = 64'h0011223344556677;
  logic [31:0] last_rd;
  logic [NC-1:0] last_mv, last_ml, last_sr;
  logic [DW-1:0] last_md [NC];

  function automatic int base_of(int c);
    return (c < NTX) ? ('h200 + 'h10 * c) : ('h400 + 'h10 * (c - NTX));
  endfunction

  function automatic logic [DW-1:0] ref_swap(logic [DW-1:0] d, int g);
    int u = 8 << g;
    int n = DW / u;
    logic [DW-1:0] r;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < u; b++) r[k*u+b] = d[(n-1-k)*u+b];
    return r;
  endfunction

  function automatic bit m_lastexp(int c);
    int lp = (mfs[c] == 0) ? 0 : mfs[c] - 1;
    return mpos[c] >= lp;
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] r = '0;
    if (a == 'h020)
      for (int c = 0; c < NC; c++)
        if (mrun[c] || mq[c].size() > 0) r[(c < NTX) ? 16 + c : 24 + c - NTX] = 1'b1;
    for (int c = 0; c < NC; c++) begin
      if (a == base_of(c))
        r = {23'd0, mrun[c], 2'd0, 2'(mgran[c]), 1'b0, men[c], mq[c].size() > 0, merr[c]};
      if (a == base_of(c) + 4) r = 32'(mfs[c]);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      mq[c].delete();
      mrun[c] = 0; men[c] = 0; merr[c] = 0; mgran[c] = 0; mfs[c] = 0; mpos[c] = 0;
    end
  endtask

  // one cycle: drive at negedge, compare, advance model, wait next negedge
  task automatic step();
    for (int c = 0; c < NC; c++) begin
      s_valid[c] = ($urandom % 100) < vp;
      s_data[c*DW +: DW] = fixed_en ? fixed_word : {$urandom, $urandom};
      m_ready[c] = ($urandom % 100) < rp;
    end
    if (rnd_rd) begin
      case ($urandom % 4)
        0: reg_raddr = 12'h020;
        1: reg_raddr = AW'(base_of($urandom % NC));
        2: reg_raddr = AW'(base_of($urandom % NC) + 4);
        default: reg_raddr = AW'($urandom % 'h600);
      endcase
    end
    #1;
    last_rd = reg_rdata; last_mv = m_valid; last_ml = m_last; last_sr = s_ready;
    for (int c = 0; c < NC; c++) last_md[c] = m_data[c*DW +: DW];
    if (rst_n) begin
      chk(reg_rdata == model_read(int'(reg_raddr)), "R2 readback", reg_rdata, model_read(int'(reg_raddr)));
      for (int c = 0; c < NC; c++) begin
        bit e_sr = mrun[c] ? (mq[c].size() < DEP) : 1'b1;
        bit e_mv = mrun[c] && mq[c].size() > 0;
        chk(s_ready[c] == e_sr, "R4 s_ready", s_ready[c], e_sr);
        chk(m_valid[c] == e_mv, "R3 m_valid", m_valid[c], e_mv);
        if (e_mv) begin
          chk(m_data[c*DW +: DW] == mq[c][0], "R3 m_data", m_data[c*DW +: DW], mq[c][0]);
          chk(m_last[c] == m_lastexp(c), "R10 m_last", m_last[c], m_lastexp(c));
        end
      end
      for (int c = 0; c < NC; c++) begin
        bit cw = reg_wr && (int'(reg_addr) == base_of(c));
        bit fwr = reg_wr && (int'(reg_addr) == base_of(c) + 4);
        bit pre_empty = mq[c].size() == 0;
        bit e_mv = mrun[c] && !pre_empty;
        bit hs = e_mv && m_ready[c];
        bit push = mrun[c] && s_valid[c] && mq[c].size() < DEP;
        bit pop = mrun[c] ? hs : !pre_empty;
        bit last = m_lastexp(c);
        bit new_en = cw ? reg_wdata[1] : men[c];
        logic [DW-1:0] pw = ref_swap(s_data[c*DW +: DW], mgran[c]);
        if (!mrun[c]) mpos[c] = 0;
        else if (hs) mpos[c] = last ? 0 : mpos[c] + 1;
        if (cw && reg_wdata[0]) merr[c] = 0;
        else if (cw && reg_wdata[1] && !mrun[c] && !pre_empty) merr[c] = 1;
        mrun[c] = new_en && (mrun[c] || pre_empty);
        men[c] = new_en;
        if (cw) mgran[c] = int'(reg_wdata[5:4]);
        if (fwr) mfs[c] = int'(reg_wdata);
        if (pop) void'(mq[c].pop_front());
        if (push) mq[c].push_back(pw);
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic peek(int a, output logic [31:0] v);
    reg_raddr = AW'(a);
    step();
    v = last_rd;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  logic [31:0] v;
  initial begin
    logic [63:0] exp_sw [4];
    int hs_n, last_n, wait_n;
    exp_sw[0] = 64'h7766554433221100; exp_sw[1] = 64'h6677445522330011;
    exp_sw[2] = 64'h4455667700112233; exp_sw[3] = 64'h0011223344556677;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek('h200, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    chk(last_sr == '1, "R1 s_ready after reset", last_sr, '1);
    chk(last_mv == '0, "R1 m_valid after reset", last_mv, 0);
    peek('h020, v); chk(v == 0, "R1 global status after reset", v, 0);

    // R2 address map
    wr('h204, 3);
    peek('h204, v); chk(v == 3, "R2 frame reg tx0", v, 3);
    wr('h404, 5);
    peek('h404, v); chk(v == 5, "R2 frame reg rx0", v, 5);
    peek('h208, v); chk(v == 0, "R2 unmapped reads 0", v, 0);
    peek('h414, v); chk(v == 0, "R2 rx1 frame untouched", v, 0);

    // R9 reorder unit sizes
    for (int g = 0; g < 4; g++) begin
      vp = 0; rp = 0;
      wr('h200, 32'(2 | (g << 4)));
      vp = 100; fixed_en = 1; step();
      vp = 0; step();
      chk(last_mv[0] && last_md[0] == exp_sw[g], "R9 reorder", last_md[0], exp_sw[g]);
      rp = 100; step(); rp = 0;
      wr('h200, 0);
    end
    fixed_en = 0;

    // R10 frame marker, frame length 3
    wr('h200, 32'h32);
    vp = 100; rp = 100; hs_n = 0; last_n = 0;
    for (int i = 0; i < 13; i++) begin
      step();
      if (last_mv[0]) begin hs_n++; if (last_ml[0]) last_n++; end
    end
    chk(hs_n == 12 && last_n == 4, "R10 last every third word", last_n, 4);
    vp = 0; wr('h200, 0);

    // R3/R11 random traffic on every channel
    for (int c = 0; c < NC; c++) begin
      wr(base_of(c) + 4, 32'(c + 1));
      wr(base_of(c), 32'(2 | ((c % 4) << 4)));
    end
    vp = 60; rp = 50; rnd_rd = 1;
    repeat (3000) step();
    rnd_rd = 0; vp = 0; rp = 0;
    peek('h020, v); chk(v == 32'h03030000, "R11 global status all live", v, 32'h03030000);

    // R5/R6/R7 close with data held, reopen while draining
    vp = 100; repeat (DEP + 2) step(); vp = 0;
    peek('h200, v); chk(v[1] == 1, "R5 busy with data held", v[1], 1);
    wr('h200, 0);
    wr('h200, 2);
    wait_n = 0;
    peek('h200, v);
    while (v[1] && wait_n < 20) begin
      chk(v[8] == 0 && last_mv[0] == 0, "R6 held off while draining", v[8], 0);
      wait_n++;
      peek('h200, v);
    end
    chk(wait_n <= DEP, "R5 drain bounded", wait_n, DEP);
    peek('h200, v); chk(v[8] == 1, "R6 runs once empty", v[8], 1);
    chk(v[0] == 1, "R7 error set by early reopen", v[0], 1);
    repeat (5) step();
    peek('h200, v); chk(v[0] == 1, "R7 error sticky", v[0], 1);
    wr('h200, 3);
    peek('h200, v); chk(v[0] == 0, "R7 clear strobe clears", v[0], 0);
    wr('h200, 3);
    repeat (2) step();
    peek('h200, v); chk(v[0] == 0 && v[2] == 1, "R8 clear not stored", v, 32'h0);

    // R4 closed channel drops words
    wr('h200, 0);
    repeat (DEP + 1) step();
    vp = 100; rp = 100;
    repeat (6) begin
      step();
      chk(last_sr[0] == 1 && last_mv[0] == 0, "R4 closed drops input", {last_sr[0], last_mv[0]}, 2'b10);
    end
    vp = 0;
    peek('h200, v); chk(v[1] == 0, "R4 nothing buffered while closed", v[1], 0);

    finish_run();
  end
endmodule